// File: doc/BRIEF.md
# Converter Output Pipeline with Tristate Bus Control

This block is the digital back end of a 10-bit sampling converter. It takes a new sample word on every period of the conversion clock and passes it through a fixed pipeline. It then drives the word onto a parallel output bus. Words are taken on one edge of the internal conversion clock and launched on the opposite edge. A word therefore reaches the bus five and a half periods after it is taken.

Two register inputs shape the clocking. One inverts the polarity of the conversion clock. The other chooses whether the launch register runs from the conversion clock or from a separate output clock. Three independent conditions release the bus to high impedance: an output-disable register bit, a power-down register bit and a low level on the active-low standby pin. A pad-enable output goes with the bus so that a pad ring can use the same enable. The analog front end and the serial register port are outside this block. Their results arrive here as plain input signals.

Top module: `adc_out_stage`

## Requirements
- R1: Output coding is straight binary. When the bus is enabled, the bus word equals the sampled word bit for bit: 0x000 stays 0x000 and 0x3FF stays 0x3FF.
- R2: The sample input is taken on the falling edge of the internal conversion clock. A change to the sample input after that edge has no effect on the word taken in that period.
- R3: With the conversion clock selected as launch clock, a word taken at a falling edge appears on the bus at the rising edge 5.5 periods later. It stays there for one full period.
- R4: The active-low reset `rst_n` clears every pipeline stage and the launch register without waiting for a clock. During reset, and until the first sampled word arrives, the enabled bus reads 0x000.
- R5: While `out_dis_i` is 1, `data_oe_o` is 0 and the bus is high impedance.
- R6: While `stby_n_i` is 0, `data_oe_o` is 0 and the bus is high impedance.
- R7: While `pwr_dn_i` is 1, `data_oe_o` is 0 and the bus is high impedance.
- R8: When none of the three disable conditions holds, `data_oe_o` is 1. Disabling never stalls the pipeline: words taken before, during and after a disable window reach the bus in their normal slots once the bus is enabled again.
- R9: With `clk_inv_i` = 1 the internal conversion clock is the inverse of `conv_clk_i`. Words are then taken on rising edges of `conv_clk_i` and launched on its falling edges, and the latency is still 5.5 periods.
- R10: With `oclk_sel_i` = 1 the launch register updates only on rising edges of `out_clk_i`. It loads the word held in the last pipeline stage, which is a word taken five internal-clock rising edges earlier. While `out_clk_i` is idle the bus holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_clk_i | input | 1 | Conversion clock |
| out_clk_i | input | 1 | Alternative launch clock for the output bus |
| clk_inv_i | input | 1 | 1 inverts the conversion clock polarity |
| oclk_sel_i | input | 1 | Launch clock select: 0 conversion clock, 1 output clock |
| out_dis_i | input | 1 | Output-disable register bit, 1 releases the bus |
| pwr_dn_i | input | 1 | Power-down register bit, 1 releases the bus |
| stby_n_i | input | 1 | Standby pin, active low, 0 releases the bus |
| sample_i | input | 10 | Sample word from the converter core |
| data_o | output | 10 | Tristate parallel output bus |
| data_oe_o | output | 1 | Pad enable for the output bus, 1 = driving |

## Verification
The interesting collision is a bus disable that lands on the very cycle a known word is launched. In that cycle the enable logic and the pipeline both act, and a faulty design could stall, drop or shift the stream. The bench raises each disable source alone, and two of them together, on cycles when specific words reach the bus. Every cycle it compares the pad enable with the disable state it drove itself. The words that follow the disable window must appear at exactly their 5.5-period slots, which shows the stream kept moving behind the high-impedance bus.

// File: rtl/adc_out_pkg.sv
`timescale 1ns/1ps
package adc_out_pkg;

   // default geometry of the output stage
   localparam int ADC_W_DEF   = 10;
   localparam int LAT_CYC_DEF = 5;

   // which clock launches the output word
   typedef enum logic {
      LSRC_CONV = 1'b0,
      LSRC_OUT  = 1'b1
   } lsrc_e;

endpackage

// File: rtl/adc_clk_ctrl.sv
`timescale 1ns/1ps
module adc_clk_ctrl
   import adc_out_pkg::*;
#(
   parameter bit OCLK_MUX_EN = 1'b1
) (
   input  logic  conv_clk_i,
   input  logic  out_clk_i,
   input  logic  inv_i,
   input  lsrc_e lsrc_i,
   output logic  ck_o,
   output logic  lclk_o
);

   // polarity-adjusted conversion clock
   assign ck_o = conv_clk_i ^ inv_i;

   generate
      if (OCLK_MUX_EN) begin : g_mux
         assign lclk_o = (lsrc_i == LSRC_OUT) ? out_clk_i : ck_o;
      end else begin : g_fixed
         logic unused_sel;
         assign unused_sel = out_clk_i ^ lsrc_i;
         assign lclk_o     = ck_o;
      end
   endgenerate

endmodule

// File: rtl/adc_pipe.sv
`timescale 1ns/1ps
module adc_pipe #(
   parameter int DATA_W  = 10,
   parameter int LAT_CYC = 5
) (
   input  logic              ck_i,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] cap_o,
   output logic [DATA_W-1:0] first_o,
   output logic [DATA_W-1:0] last_o
);

   localparam int LAST = LAT_CYC - 1;

   logic [DATA_W-1:0]              cap_q;
   logic [LAT_CYC-1:0][DATA_W-1:0] stg_q;

   // half-cycle capture stage on the falling edge
   always_ff @(negedge ck_i or negedge rst_n) begin
      if (!rst_n) cap_q <= '0;
      else        cap_q <= d_i;
   end

   // whole-cycle delay chain on the rising edge
   always_ff @(posedge ck_i or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= cap_q;
         for (int i = 1; i < LAT_CYC; i++) begin
            stg_q[i] <= stg_q[i-1];
         end
      end
   end

   assign cap_o   = cap_q;
   assign first_o = stg_q[0];
   assign last_o  = stg_q[LAST];

endmodule

// File: rtl/adc_launch_reg.sv
`timescale 1ns/1ps
module adc_launch_reg #(
   parameter int DATA_W = 10
) (
   input  logic              lclk_i,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);

   always_ff @(posedge lclk_i or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= d_i;
   end

endmodule

// File: rtl/adc_oe_ctrl.sv
`timescale 1ns/1ps
module adc_oe_ctrl (
   input  logic dis_i,
   input  logic pd_i,
   input  logic stby_n_i,
   output logic oe_o
);

   logic any_off;

   assign any_off = dis_i | pd_i | ~stby_n_i;
   assign oe_o    = ~any_off;

endmodule

// File: rtl/adc_out_stage.sv
`timescale 1ns/1ps
module adc_out_stage
   import adc_out_pkg::*;
#(
   parameter int DATA_W      = ADC_W_DEF,
   parameter int LAT_CYC     = LAT_CYC_DEF,
   parameter bit OCLK_MUX_EN = 1'b1
) (
   input  logic              rst_n,
   input  logic              conv_clk_i,
   input  logic              out_clk_i,
   input  logic              clk_inv_i,
   input  logic              oclk_sel_i,
   input  logic              out_dis_i,
   input  logic              pwr_dn_i,
   input  logic              stby_n_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe_o
);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
         $error("adc_out_stage: DATA_W out of range 1..32");
      end
      if (LAT_CYC < 1 || LAT_CYC > 64) begin : g_bad_lat
         $error("adc_out_stage: LAT_CYC out of range 1..64");
      end
   endgenerate

   logic              ck_int;
   logic              lclk;
   logic              oe;
   lsrc_e             lsrc;
   logic [DATA_W-1:0] cap_q;
   logic [DATA_W-1:0] first_q;
   logic [DATA_W-1:0] last_q;
   logic [DATA_W-1:0] data_q;

   assign lsrc = lsrc_e'(oclk_sel_i);

   adc_clk_ctrl #(
      .OCLK_MUX_EN(OCLK_MUX_EN)
   ) u_clk (
      .conv_clk_i(conv_clk_i),
      .out_clk_i (out_clk_i),
      .inv_i     (clk_inv_i),
      .lsrc_i    (lsrc),
      .ck_o      (ck_int),
      .lclk_o    (lclk)
   );

   adc_pipe #(
      .DATA_W (DATA_W),
      .LAT_CYC(LAT_CYC)
   ) u_pipe (
      .ck_i   (ck_int),
      .rst_n  (rst_n),
      .d_i    (sample_i),
      .cap_o  (cap_q),
      .first_o(first_q),
      .last_o (last_q)
   );

   adc_launch_reg #(
      .DATA_W(DATA_W)
   ) u_launch (
      .lclk_i(lclk),
      .rst_n (rst_n),
      .d_i   (last_q),
      .q_o   (data_q)
   );

   adc_oe_ctrl u_oe (
      .dis_i   (out_dis_i),
      .pd_i    (pwr_dn_i),
      .stby_n_i(stby_n_i),
      .oe_o    (oe)
   );

   assign data_oe_o = oe;
   assign data_o    = oe ? data_q : {DATA_W{1'bz}};

endmodule

// File: rtl/adc_out_stage_chk.sv
`timescale 1ns/1ps
module adc_out_stage_chk #(
   parameter int DATA_W = 10
) (
   input logic              rst_n,
   input logic              conv_clk_i,
   input logic              ck_int,
   input logic              lclk,
   input logic              out_dis_i,
   input logic              pwr_dn_i,
   input logic              stby_n_i,
   input logic              data_oe_o,
   input logic [DATA_W-1:0] sample_i,
   input logic [DATA_W-1:0] cap_q,
   input logic [DATA_W-1:0] first_q,
   input logic [DATA_W-1:0] last_q,
   input logic [DATA_W-1:0] data_q
);

   AST_CAPTURE_ON_FALL: assert property (@(negedge ck_int) disable iff (!rst_n)
      cap_q == $past(sample_i)); // R2

   AST_CHAIN_ADVANCE: assert property (@(posedge ck_int) disable iff (!rst_n)
      first_q == $past(cap_q)); // R3

   AST_LAUNCH_FROM_LAST: assert property (@(posedge lclk) disable iff (!rst_n)
      data_q == $past(last_q)); // R10

   AST_DIS_RELEASES_BUS: assert property (@(posedge conv_clk_i) disable iff (!rst_n)
      out_dis_i |-> !data_oe_o); // R5

   AST_STBY_RELEASES_BUS: assert property (@(posedge conv_clk_i) disable iff (!rst_n)
      !stby_n_i |-> !data_oe_o); // R6

   AST_PD_RELEASES_BUS: assert property (@(posedge conv_clk_i) disable iff (!rst_n)
      pwr_dn_i |-> !data_oe_o); // R7

   AST_BUS_DRIVEN_WHEN_ON: assert property (@(posedge conv_clk_i) disable iff (!rst_n)
      (!out_dis_i && !pwr_dn_i && stby_n_i) |-> data_oe_o); // R8

endmodule

bind adc_out_stage adc_out_stage_chk #(.DATA_W(DATA_W)) u_chk (
   .rst_n     (rst_n),
   .conv_clk_i(conv_clk_i),
   .ck_int    (ck_int),
   .lclk      (lclk),
   .out_dis_i (out_dis_i),
   .pwr_dn_i  (pwr_dn_i),
   .stby_n_i  (stby_n_i),
   .data_oe_o (data_oe_o),
   .sample_i  (sample_i),
   .cap_q     (cap_q),
   .first_q   (first_q),
   .last_q    (last_q),
   .data_q    (data_q)
);

// File: tb/adc_out_stage_tb.sv
`timescale 1ns/1ps
module adc_out_stage_tb_top;

   localparam int W = 10;

   logic         rst_n    = 1'b0;
   logic         conv_clk = 1'b0;
   logic         oclk_d   = 1'b0;
   logic         out_run  = 1'b1;
   logic         out_clk;
   logic         clk_inv  = 1'b0;
   logic         oclk_sel = 1'b0;
   logic         out_dis  = 1'b0;
   logic         pwr_dn   = 1'b0;
   logic         stby_n   = 1'b1;
   logic [W-1:0] sample   = '0;
   wire  [W-1:0] data_o;
   logic         data_oe;
   logic         lclk_tb;

   int           n_chk = 0;
   int           n_fail = 0;
   logic [W-1:0] sb_w[$];
   string        sb_tag[$];
   logic         mon_on = 1'b0;
   logic [W-1:0] exp_w;
   string        exp_tag;
   logic         exp_oe;
   string        oe_tag;
   logic [W-1:0] hold_v;

   // 200 MHz conversion clock, output clock lags it by 1 ns
   always #2.5 conv_clk = ~conv_clk;
   always @(conv_clk) begin
      #1;
      oclk_d = conv_clk;
   end
   assign out_clk = oclk_d & out_run;
   assign lclk_tb = conv_clk ^ clk_inv;

   adc_out_stage dut_i (
      .rst_n     (rst_n),
      .conv_clk_i(conv_clk),
      .out_clk_i (out_clk),
      .clk_inv_i (clk_inv),
      .oclk_sel_i(oclk_sel),
      .out_dis_i (out_dis),
      .pwr_dn_i  (pwr_dn),
      .stby_n_i  (stby_n),
      .sample_i  (sample),
      .data_o    (data_o),
      .data_oe_o (data_oe)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, expv, $time);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // monitor: pops one expected item per internal clock period
   always @(posedge lclk_tb) begin
      #2;
      if (mon_on) begin
         exp_w   = sb_w.pop_front();
         exp_tag = sb_tag.pop_front();
         exp_oe  = !(out_dis || pwr_dn || !stby_n);
         oe_tag  = out_dis ? "R5" : (pwr_dn ? "R7" : (!stby_n ? "R6" : "R8"));
         check(data_oe === exp_oe, oe_tag, "pad enable",
               {{(W-1){1'b0}}, data_oe}, {{(W-1){1'b0}}, exp_oe});
         if (exp_oe) check(data_o === exp_w, exp_tag, "bus word", data_o, exp_w);
      end
   end

   // driver: one word per period, junk after the capture edge (R2)
   task automatic push_cycle(input logic [W-1:0] w, input string tag,
                             input bit dis, input bit pd, input bit sb);
      @(posedge lclk_tb);
      #0.5;
      sample  = w;
      out_dis = dis;
      pwr_dn  = pd;
      stby_n  = sb;
      sb_w.push_back(w);
      sb_tag.push_back(tag);
      mon_on  = 1'b1;
      #3;
      sample  = ~w;
   endtask

   task automatic do_reset(input bit inv, input bit sel, input int slots);
      mon_on   = 1'b0;
      rst_n    = 1'b0;
      clk_inv  = inv;
      oclk_sel = sel;
      out_dis  = 1'b0;
      pwr_dn   = 1'b0;
      stby_n   = 1'b1;
      sample   = '0;
      repeat (3) @(posedge conv_clk);
      #1;
      check(data_oe === 1'b1 && data_o === '0, "R4", "reset state", data_o, '0);
      @(posedge lclk_tb);
      #0.5;
      rst_n = 1'b1;
      sb_w.delete();
      sb_tag.delete();
      for (int i = 0; i < slots; i++) begin
         sb_w.push_back('0);
         sb_tag.push_back("R4");
      end
   endtask

   task automatic run_stream(input int n, input string tag, input bit with_dis);
      for (int k = 0; k < n + 7; k++) begin
         logic [W-1:0] w;
         string        t;
         bit           d, p, s;
         w = W'((k * 149 + 23) % 1024);
         t = tag;
         if (k == 2) begin w = '0; t = "R1"; end
         if (k == 3) begin w = '1; t = "R1"; end
         d = with_dis && (k == 8 || k == 9 || k == 13);
         p = with_dis && (k == 11 || k == 13);
         s = !(with_dis && (k == 15 || k == 16));
         push_cycle(w, t, d, p, s);
      end
      @(posedge lclk_tb);
      #0.5;
      mon_on  = 1'b0;
      out_dis = 1'b0;
      pwr_dn  = 1'b0;
      stby_n  = 1'b1;
   endtask

   initial begin
      #1000000;
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog expired: actual %h expected %h", data_o, data_o);
      summary();
   end

   initial begin
      // conversion-clock launch, disable windows over the stream
      do_reset(1'b0, 1'b0, 6);
      run_stream(24, "R3", 1'b1);
      // plain stream, capture edge checked through the junk writes
      do_reset(1'b0, 1'b0, 6);
      run_stream(16, "R2", 1'b0);
      // inverted conversion clock
      do_reset(1'b1, 1'b0, 6);
      run_stream(16, "R9", 1'b0);
      // separate output clock: launch one period earlier here
      do_reset(1'b0, 1'b1, 5);
      run_stream(16, "R10", 1'b1);
      // idle output clock: bus must hold while the pipeline moves
      @(posedge lclk_tb);
      #0.5;
      out_run = 1'b0;
      #1;
      hold_v = data_o;
      for (int k = 0; k < 4; k++) begin
         @(posedge lclk_tb);
         #0.5;
         sample = W'(k * 77 + 300);
         #1.5;
         check(data_o === hold_v, "R10", "hold with idle output clock", data_o, hold_v);
      end
      out_run = 1'b1;
      repeat (2) @(posedge conv_clk);
      summary();
   end

endmodule